// File: doc/BRIEF.md
# Lane Sync-Request Handshake Controller

This block drives the active-low synchronization request that a multi-gigabit converter receiver returns to its transmitter. The request stays asserted through reset. After reset it counts an unbroken run of comma (/K/) characters reported once per link-clock cycle. When the run is long enough, the block drops the request so that the link can move on to lane alignment.

In the deterministic-latency subclasses (any non-zero mode), a rising edge on SYSREF must also have been captured. SYSREF realigns the local multiframe counter, so gating the release on it means the release follows the realigned count and not the free-running one. In every mode the release takes effect only in a cycle that the multiframe-boundary pulse marks. If the comma run breaks after release, the request is raised again. The captured SYSREF event is kept, so a later release does not need a new SYSREF edge.

Top module: `lane_sync_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `sync_req_n` is 0 after that edge, whatever the other inputs do.
- R2: The block keeps a count of consecutive cycles with `k_valid`=1. A cycle with `k_valid`=0 clears the count, and the next K cycle restarts it at 1.
- R3: The comma threshold is `k_need`. A `k_need` of 0 selects the default threshold of 4. The run is long enough once the registered count is at least the threshold.
- R4: With `mode`=0, a long-enough run and a boundary pulse release the request. SYSREF is not needed.
- R5: With `mode` in 1, 2 or 3, release also requires that `sysref_seen` was 1 in the cycle before the release edge.
- R6: A SYSREF rising edge is found from two link-clock samples. `sysref_seen` becomes 1 two edges after SYSREF is first sampled high, then stays 1 until reset. `sysref_seen` is 0 after reset.
- R7: `sync_req_n` rises only after an edge at which `mf_edge` was 1.
- R8: Once released, a break in the comma run raises the request again: `sync_req_n` is 0 two edges after the first `k_valid`=0 cycle. `sysref_seen` stays 1 through this.
- R9: The run count saturates, so a run longer than the counter range keeps the run long enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous reset, active high |
| k_valid | input | 1 | A /K/ character arrived this cycle |
| sysref | input | 1 | SYSREF timing reference |
| mf_edge | input | 1 | Multiframe boundary pulse, one cycle |
| mode | input | 2 | Subclass select: 0, 1, 2 (3 acts as 1) |
| k_need | input | CNT_W (8) | Required comma run length; 0 means 4 |
| sync_req_n | output | 1 | Synchronization request, active low |
| sysref_seen | output | 1 | A SYSREF rising edge has been captured |

## Verification
The bench keeps the default 8-bit counter and the default threshold of 4. The 8-bit width lets a threshold of 255 be driven, so a 300-cycle comma run shows the release edge at the counter limit and shows that saturation does not drop the link. Leaving `k_need` at 0 covers the default threshold. Small explicit thresholds of 1 to 3 keep the subclass 1 and 2 gating and the re-request after a broken run within a few cycles. Those cases can be checked edge by edge.

// File: rtl/lane_sync_pkg.sv
package lane_sync_pkg;

  typedef enum logic [1:0] {
    SC_ZERO = 2'd0,
    SC_ONE  = 2'd1,
    SC_TWO  = 2'd2,
    SC_RSV  = 2'd3
  } subclass_e;

  typedef enum logic {
    ST_REQUEST = 1'b0,
    ST_LINKED  = 1'b1
  } sync_state_e;

  // Deterministic-latency subclasses wait for a captured SYSREF edge.
  function automatic logic sysref_gated(input logic [1:0] m);
    return subclass_e'(m) != SC_ZERO;
  endfunction

endpackage

// File: rtl/lane_sync_kcount.sv
module lane_sync_kcount #(
  parameter int CNT_W    = 8,
  parameter int DEF_NEED = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             k_valid,
  input  logic [CNT_W-1:0] k_need,
  output logic             k_ok
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] NEED_D  = CNT_W'(DEF_NEED);

  function automatic logic [CNT_W-1:0] eff_need(input logic [CNT_W-1:0] n);
    return (n == '0) ? NEED_D : n;
  endfunction

  function automatic logic [CNT_W-1:0] next_run(input logic [CNT_W-1:0] c,
                                                input logic kv);
    if (!kv)            return '0;
    else if (c == CNT_MAX) return CNT_MAX;
    else                return c + 1'b1;
  endfunction

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] need_w;

  assign need_w = eff_need(k_need);

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= next_run(run_q, k_valid);
  end

  assign k_ok = (run_q >= need_w);

  // R2: a missing K clears the run
  p_run_clears_r2: assert property (@(posedge clk) disable iff (rst)
    !k_valid |=> (run_q == '0));
  // R9: a full counter does not wrap while K keeps arriving
  p_run_saturates_r9: assert property (@(posedge clk) disable iff (rst)
    (k_valid && run_q == CNT_MAX) |=> (run_q == CNT_MAX));

endmodule

// File: rtl/lane_sync_sysref.sv
module lane_sync_sysref (
  input  logic clk,
  input  logic rst,
  input  logic sysref,
  output logic seen
);
  logic smp_now_q, smp_prev_q;
  logic seen_q;
  logic rise_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_now_q  <= 1'b0;
      smp_prev_q <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      smp_now_q  <= sysref;
      smp_prev_q <= smp_now_q;
      if (rise_w) seen_q <= 1'b1;
    end
  end

  assign rise_w = smp_now_q & ~smp_prev_q;
  assign seen   = seen_q;

  // R6: the flag sticks until reset
  p_seen_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    seen_q |=> seen_q);
  // R6: the flag only sets after a detected rising edge
  p_seen_from_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(seen_q) |-> $past(rise_w));

endmodule

// File: rtl/lane_sync_fsm.sv
module lane_sync_fsm
  import lane_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       k_ok,
  input  logic       seen,
  input  logic       mf_edge,
  input  logic [1:0] mode,
  output logic       sync_req_n
);
  sync_state_e st_q, st_d;
  logic        release_ok;

  assign release_ok = k_ok && (!sysref_gated(mode) || seen) && mf_edge;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_REQUEST: if (release_ok) st_d = ST_LINKED;
      ST_LINKED:  if (!k_ok)      st_d = ST_REQUEST;
      default:    st_d = ST_REQUEST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_REQUEST;
    else     st_q <= st_d;
  end

  assign sync_req_n = (st_q == ST_LINKED);

  // R1: reset forces the request asserted
  p_reset_req_r1: assert property (@(posedge clk)
    rst |=> !sync_req_n);
  // R7: release only at a multiframe boundary
  p_release_on_mf_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_req_n) |-> $past(mf_edge));
  // R3: release only with a long enough run
  p_release_needs_k_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_req_n) |-> $past(k_ok));
  // R5: gated subclasses need a captured SYSREF edge
  p_release_needs_sysref_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(sync_req_n) && $past(sysref_gated(mode))) |-> $past(seen));
  // R8: losing the run while linked re-requests
  p_relink_on_loss_r8: assert property (@(posedge clk) disable iff (rst)
    (sync_req_n && !k_ok) |=> !sync_req_n);

endmodule

// File: rtl/lane_sync_ctrl.sv
module lane_sync_ctrl #(
  parameter int CNT_W    = 8,
  parameter int DEF_NEED = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             k_valid,
  input  logic             sysref,
  input  logic             mf_edge,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] k_need,
  output logic             sync_req_n,
  output logic             sysref_seen
);
  logic run_long;
  logic ref_seen;

  lane_sync_kcount #(.CNT_W(CNT_W), .DEF_NEED(DEF_NEED)) u_kcount (
    .clk     (clk),
    .rst     (rst),
    .k_valid (k_valid),
    .k_need  (k_need),
    .k_ok    (run_long)
  );

  lane_sync_sysref u_sysref (
    .clk    (clk),
    .rst    (rst),
    .sysref (sysref),
    .seen   (ref_seen)
  );

  lane_sync_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .k_ok       (run_long),
    .seen       (ref_seen),
    .mf_edge    (mf_edge),
    .mode       (mode),
    .sync_req_n (sync_req_n)
  );

  assign sysref_seen = ref_seen;

  // R6: the status output is clear after reset
  p_seen_reset_r6: assert property (@(posedge clk)
    rst |=> !sysref_seen);

endmodule

// File: tb/sim_lane_sync_ctrl.sv
module sim_lane_sync_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       k_valid = 1'b0, sysref = 1'b0, mf_edge = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] k_need = 8'd0;
  logic       sync_req_n, sysref_seen;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #10 clk = ~clk; // 50 MHz

  lane_sync_ctrl u0 (
    .clk(clk), .rst(rst), .k_valid(k_valid), .sysref(sysref),
    .mf_edge(mf_edge), .mode(mode), .k_need(k_need),
    .sync_req_n(sync_req_n), .sysref_seen(sysref_seen)
  );

  // {k_valid, sysref, mf_edge, expected sync_req_n, expected sysref_seen}
  // mode 1, k_need 3, one row per clock edge after reset
  localparam logic [4:0] VEC [14] = '{
    5'b10000, 5'b10100, 5'b10100, 5'b10100, // R5: run long, no SYSREF yet
    5'b11000, 5'b11001,                     // R6: seen two edges later
    5'b10001, 5'b10111,                     // R7: waits for boundary, then releases
    5'b10011, 5'b00011,                     // still linked
    5'b10001, 5'b10101, 5'b10101, 5'b10111  // R8: re-request, seen kept, relink
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic kv, input logic sr, input logic mf);
    k_valid = kv; sysref = sr; mf_edge = mf;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    // R1: reset holds the request even with K and boundaries present
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1);
    chk("R1 sync during reset", sync_req_n, 1'b0);
    do_reset();
    chk("R1 sync after reset", sync_req_n, 1'b0);
    chk("R6 seen after reset", sysref_seen, 1'b0);

    // vector table: subclass 1
    mode = 2'd1; k_need = 8'd3;
    for (int i = 0; i < 14; i++) begin
      step(VEC[i][4], VEC[i][3], VEC[i][2]);
      chk($sformatf("R5/R7/R8 vec%0d sync", i), sync_req_n, VEC[i][1]);
      chk($sformatf("R6/R8 vec%0d seen", i), sysref_seen, VEC[i][0]);
    end

    // R3/R4: mode 0, k_need 0 -> default threshold 4, no SYSREF
    do_reset();
    mode = 2'd0; k_need = 8'd0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1);
    chk("R3 default threshold not yet", sync_req_n, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    chk("R4 mode0 release without sysref", sync_req_n, 1'b1);
    chk("R4 seen stays 0", sysref_seen, 1'b0);

    // R2: break restarts the run (k_need 2, mode 0)
    do_reset();
    k_need = 8'd2;
    step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    chk("R2 run restarted after break", sync_req_n, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk("R7 no release without boundary", sync_req_n, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    chk("R7 release at boundary", sync_req_n, 1'b1);

    // R5: mode 2 behaves like mode 1
    do_reset();
    mode = 2'd2; k_need = 8'd1;
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    chk("R5 mode2 blocked without sysref", sync_req_n, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    chk("R5 mode2 seen set", sysref_seen, 1'b1);
    chk("R5 mode2 one edge lag", sync_req_n, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    chk("R5 mode2 release", sync_req_n, 1'b1);

    // R1/R6: reset mid-link clears both outputs
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b1);
    chk("R1 sync after mid-run reset", sync_req_n, 1'b0);
    chk("R6 seen after mid-run reset", sysref_seen, 1'b0);
    rst = 1'b0;

    // R9: threshold 255 and saturation on a long run
    do_reset();
    mode = 2'd0; k_need = 8'd255;
    for (int i = 0; i < 255; i++) step(1'b1, 1'b0, 1'b1);
    chk("R9 255 not yet", sync_req_n, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    chk("R9 release at 255", sync_req_n, 1'b1);
    for (int i = 0; i < 44; i++) step(1'b1, 1'b0, 1'b1);
    chk("R9 saturated run stays linked", sync_req_n, 1'b1);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule